// File: doc/BRIEF.md
# Split Instruction/Data Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 4 KB page machine whose virtual addresses fit in 26 bits. It holds two independent associative arrays. Instruction fetches use a small array with exact least-recently-used replacement. Data accesses use a larger array whose victim is picked by a pseudo-random sequence. Each lookup is steered to one half by its category flag. The answer comes back one cycle later: hit or miss, the translated physical address, and the echoed page number and flags. A miss gives the outside walker what it needs to compute a refill.

The walker writes a refill into the half it names. A refill first replaces an entry that already holds the same page. If there is none, it takes the lowest free way of the set. Only when the set is full does the half's replacement policy pick the victim. A flush empties both halves in one cycle. Each half keeps a saturating access counter and a saturating hit counter on output ports.

Top module: `split_tlb`

## Requirements
- R1: After reset no translation is valid, all four counters read zero and `rsp_valid` is low.
- R2: A lookup presented in cycle N produces `rsp_valid` in cycle N+1, along with the echoed category, write flag and 14-bit page number (vaddr[25:12]). On a hit `rsp_paddr` is {ppn, vaddr[11:0]}. On a miss it is zero.
- R3: The instruction half has 4 sets of 4 ways, indexed by vpn[1:0]. The data half has 8 sets of 4 ways, indexed by vpn[2:0]. The remaining page-number bits form the tag, so each half holds a full complement of distinct pages.
- R4: The halves are independent. A translation written into one half is never returned for a lookup whose category selects the other half (`lk_is_instr`=1 selects the instruction half).
- R5: A refill of a page already held in the set overwrites its physical page number in place. Otherwise the refill goes to the lowest-numbered invalid way.
- R6: In a full instruction set, a refill evicts the least recently used way. Both hits and refills count as uses.
- R7: In a full data set, the victim way is the low 2 bits of a 16-bit LFSR. The LFSR is reset to 16'hACE1 and advances only when a random victim is taken. Each step shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R8: Each half counts the lookups steered to it and, separately, its hits. The counts are visible the cycle after the lookup.
- R9: Counters saturate at all ones instead of wrapping. They are `CNT_W` bits wide, 32 by default.
- R10: A flush invalidates every entry in one cycle. A lookup in the following cycle misses, and the counters are left unchanged.
- R11: Flush takes priority over a refill in the same cycle, which is dropped. A refill in the same cycle as a lookup does not change that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries of both halves |
| lk_valid | input | 1 | Lookup request |
| lk_is_instr | input | 1 | 1 = instruction half, 0 = data half |
| lk_is_write | input | 1 | Write access flag, echoed |
| lk_vaddr | input | 26 | Virtual address |
| fill_valid | input | 1 | Refill request |
| fill_is_instr | input | 1 | Half that receives the refill |
| fill_vpn | input | 14 | Virtual page number of the refill |
| fill_ppn | input | 8 | Physical page number of the refill |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_is_instr | output | 1 | Echoed category |
| rsp_is_write | output | 1 | Echoed write flag |
| rsp_vpn | output | 14 | Echoed virtual page number |
| rsp_paddr | output | 20 | Physical address on hit, zero on miss |
| icnt_access | output | CNT_W | Instruction-half lookups |
| icnt_hit | output | CNT_W | Instruction-half hits |
| dcnt_access | output | CNT_W | Data-half lookups |
| dcnt_hit | output | CNT_W | Data-half hits |

## Verification
A corrupted recency order or LFSR value stays hidden until a set fills. It then shows at the ports only on the next lookup of the page that should have survived, or the one that should have been evicted. The bench therefore tracks set contents and the LFSR in its own model and probes every page after each eviction. A wrong valid bit or tag shows one cycle after the lookup, as a wrong `rsp_hit`. Counter faults show one cycle after the lookup that should have moved them.

// File: rtl/split_tlb.sv
module split_tlb #(
  parameter int VA_W = 26,
  parameter int PG_W = 12,
  parameter int PPN_W = 8,
  parameter int I_IDX_W = 2,
  parameter int D_IDX_W = 3,
  parameter int CNT_W = 32,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int VPN_W = VA_W - PG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_valid,
  input  logic               lk_is_instr,
  input  logic               lk_is_write,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic               fill_valid,
  input  logic               fill_is_instr,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_is_instr,
  output logic               rsp_is_write,
  output logic [VPN_W-1:0]   rsp_vpn,
  output logic [PPN_W+PG_W-1:0] rsp_paddr,
  output logic [CNT_W-1:0]   icnt_access,
  output logic [CNT_W-1:0]   icnt_hit,
  output logic [CNT_W-1:0]   dcnt_access,
  output logic [CNT_W-1:0]   dcnt_hit
);

  localparam int WAYS    = 4;
  localparam int I_SETS  = 1 << I_IDX_W;
  localparam int D_SETS  = 1 << D_IDX_W;
  localparam int I_TAG_W = VPN_W - I_IDX_W;
  localparam int D_TAG_W = VPN_W - D_IDX_W;

  function automatic logic [1:0] low_way(input logic [WAYS-1:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int k = WAYS - 1; k >= 0; k--)
      if (v[k]) r = 2'(k);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  logic [WAYS-1:0]    i_vld [I_SETS];
  logic [I_TAG_W-1:0] i_tag [I_SETS][WAYS];
  logic [PPN_W-1:0]   i_ppn [I_SETS][WAYS];
  logic [1:0]         i_age [I_SETS][WAYS];
  logic [WAYS-1:0]    d_vld [D_SETS];
  logic [D_TAG_W-1:0] d_tag [D_SETS][WAYS];
  logic [PPN_W-1:0]   d_ppn [D_SETS][WAYS];
  logic [15:0]        lfsr;

  logic [VPN_W-1:0]   lk_vpn;
  logic [I_IDX_W-1:0] i_lset, i_fset;
  logic [D_IDX_W-1:0] d_lset, d_fset;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_W];
  assign i_lset = lk_vpn[I_IDX_W-1:0];
  assign d_lset = lk_vpn[D_IDX_W-1:0];
  assign i_fset = fill_vpn[I_IDX_W-1:0];
  assign d_fset = fill_vpn[D_IDX_W-1:0];

  logic [WAYS-1:0] i_lhit_v, d_lhit_v, i_fmatch_v, d_fmatch_v, i_lru_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign i_lhit_v[w]   = i_vld[i_lset][w] && (i_tag[i_lset][w] == lk_vpn[VPN_W-1:I_IDX_W]);
    assign d_lhit_v[w]   = d_vld[d_lset][w] && (d_tag[d_lset][w] == lk_vpn[VPN_W-1:D_IDX_W]);
    assign i_fmatch_v[w] = i_vld[i_fset][w] && (i_tag[i_fset][w] == fill_vpn[VPN_W-1:I_IDX_W]);
    assign d_fmatch_v[w] = d_vld[d_fset][w] && (d_tag[d_fset][w] == fill_vpn[VPN_W-1:D_IDX_W]);
    assign i_lru_v[w]    = (i_age[i_fset][w] == 2'd3);
  end

  logic       i_lhit, d_lhit, lk_hit;
  logic [1:0] i_lway, d_lway, i_fway, d_fway;
  logic [PPN_W-1:0] lk_ppn;

  assign i_lhit = |i_lhit_v;
  assign d_lhit = |d_lhit_v;
  assign i_lway = low_way(i_lhit_v);
  assign d_lway = low_way(d_lhit_v);
  assign lk_hit = lk_is_instr ? i_lhit : d_lhit;
  assign lk_ppn = lk_is_instr ? i_ppn[i_lset][i_lway] : d_ppn[d_lset][d_lway];

  assign i_fway = (|i_fmatch_v)      ? low_way(i_fmatch_v) :
                  (~&i_vld[i_fset])  ? low_way(~i_vld[i_fset]) : low_way(i_lru_v);
  assign d_fway = (|d_fmatch_v)      ? low_way(d_fmatch_v) :
                  (~&d_vld[d_fset])  ? low_way(~d_vld[d_fset]) : lfsr[1:0];

  logic i_fill, d_fill, d_rand_use;
  assign i_fill     = fill_valid && fill_is_instr && !flush;
  assign d_fill     = fill_valid && !fill_is_instr && !flush;
  assign d_rand_use = d_fill && !(|d_fmatch_v) && (&d_vld[d_fset]);

  logic               i_tch_en;
  logic [I_IDX_W-1:0] i_tch_set;
  logic [1:0]         i_tch_way, i_tch_age;
  assign i_tch_en  = i_fill || (lk_valid && lk_is_instr && i_lhit);
  assign i_tch_set = i_fill ? i_fset : i_lset;
  assign i_tch_way = i_fill ? i_fway : i_lway;
  assign i_tch_age = i_age[i_tch_set][i_tch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < I_SETS; s++) begin
        i_vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) i_age[s][w] <= 2'(w);
      end
    end else if (flush) begin
      for (int s = 0; s < I_SETS; s++) begin
        i_vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) i_age[s][w] <= 2'(w);
      end
    end else begin
      if (i_fill) i_vld[i_fset][i_fway] <= 1'b1;
      if (i_tch_en)
        for (int w = 0; w < WAYS; w++) begin
          if (2'(w) == i_tch_way) i_age[i_tch_set][w] <= 2'd0;
          else if (i_age[i_tch_set][w] < i_tch_age) i_age[i_tch_set][w] <= i_age[i_tch_set][w] + 2'd1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (i_fill) begin
      i_tag[i_fset][i_fway] <= fill_vpn[VPN_W-1:I_IDX_W];
      i_ppn[i_fset][i_fway] <= fill_ppn;
    end
    if (d_fill) begin
      d_tag[d_fset][d_fway] <= fill_vpn[VPN_W-1:D_IDX_W];
      d_ppn[d_fset][d_fway] <= fill_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < D_SETS; s++) d_vld[s] <= '0;
      lfsr <= LFSR_SEED;
    end else if (flush) begin
      for (int s = 0; s < D_SETS; s++) d_vld[s] <= '0;
    end else if (d_fill) begin
      d_vld[d_fset][d_fway] <= 1'b1;
      if (d_rand_use) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_access <= '0;
      icnt_hit    <= '0;
      dcnt_access <= '0;
      dcnt_hit    <= '0;
    end else if (lk_valid) begin
      if (lk_is_instr) begin
        icnt_access <= sat_inc(icnt_access);
        if (i_lhit) icnt_hit <= sat_inc(icnt_hit);
      end else begin
        dcnt_access <= sat_inc(dcnt_access);
        if (d_lhit) dcnt_hit <= sat_inc(dcnt_hit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_is_instr <= 1'b0;
      rsp_is_write <= 1'b0;
      rsp_vpn      <= '0;
      rsp_paddr    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit      <= lk_hit;
        rsp_is_instr <= lk_is_instr;
        rsp_is_write <= lk_is_write;
        rsp_vpn      <= lk_vpn;
        rsp_paddr    <= lk_hit ? {lk_ppn, lk_vaddr[PG_W-1:0]} : '0;
      end
    end
  end

endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
  parameter int VA_W = 26,
  parameter int PG_W = 12,
  parameter int PPN_W = 8,
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  lk_valid,
  input logic                  lk_is_instr,
  input logic                  lk_is_write,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_is_instr,
  input logic                  rsp_is_write,
  input logic [PPN_W+PG_W-1:0] rsp_paddr,
  input logic [CNT_W-1:0]      icnt_access,
  input logic [CNT_W-1:0]      icnt_hit,
  input logic [CNT_W-1:0]      dcnt_access,
  input logic [CNT_W-1:0]      dcnt_hit
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> rsp_paddr == '0); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[PG_W-1:0] == $past(lk_vaddr[PG_W-1:0]))); // R2
  AST_FLAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_is_instr == $past(lk_is_instr) && rsp_is_write == $past(lk_is_write))); // R2
  AST_I_HIT_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n) icnt_hit <= icnt_access); // R8
  AST_D_HIT_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n) dcnt_hit <= dcnt_access); // R8
  AST_I_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> icnt_access >= $past(icnt_access)); // R9
  AST_D_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> dcnt_access >= $past(dcnt_access)); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush ##1 lk_valid |=> !rsp_hit); // R10

endmodule

bind split_tlb split_tlb_chk #(.VA_W(VA_W), .PG_W(PG_W), .PPN_W(PPN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_is_instr(lk_is_instr),
  .lk_is_write(lk_is_write), .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_is_instr(rsp_is_instr), .rsp_is_write(rsp_is_write), .rsp_paddr(rsp_paddr),
  .icnt_access(icnt_access), .icnt_hit(icnt_hit), .dcnt_access(dcnt_access), .dcnt_hit(dcnt_hit)
);

// File: tb/test_split_tlb.sv
module test_split_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0, lk_is_instr = 1'b0, lk_is_write = 1'b0;
  logic [25:0] lk_vaddr = '0;
  logic fill_valid = 1'b0, fill_is_instr = 1'b0;
  logic [13:0] fill_vpn = '0;
  logic [7:0] fill_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_is_instr, rsp_is_write;
  logic [13:0] rsp_vpn;
  logic [19:0] rsp_paddr;
  logic [CW-1:0] icnt_access, icnt_hit, dcnt_access, dcnt_hit;

  int n_chk = 0, n_fail = 0;
  int m_iacc = 0, m_ihit = 0, m_dacc = 0, m_dhit = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_tlb #(.CNT_W(CW)) i_split_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_is_instr(lk_is_instr),
    .lk_is_write(lk_is_write), .lk_vaddr(lk_vaddr), .fill_valid(fill_valid),
    .fill_is_instr(fill_is_instr), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_is_instr(rsp_is_instr),
    .rsp_is_write(rsp_is_write), .rsp_vpn(rsp_vpn), .rsp_paddr(rsp_paddr),
    .icnt_access(icnt_access), .icnt_hit(icnt_hit), .dcnt_access(dcnt_access), .dcnt_hit(dcnt_hit)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_count(input bit ins, input bit hit);
    if (ins) begin m_iacc = sat(m_iacc); if (hit) m_ihit = sat(m_ihit); end
    else begin m_dacc = sat(m_dacc); if (hit) m_dhit = sat(m_dhit); end
  endtask

  task automatic lookup(input bit ins, input bit wr, input logic [13:0] vpn, input logic [11:0] off,
                        input bit eh, input logic [7:0] ep, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_is_instr = ins; lk_is_write = wr; lk_vaddr = {vpn, off};
    @(negedge clk);
    lk_valid = 1'b0;
    model_count(ins, eh);
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_hit", 32'(rsp_hit), 32'(eh));
    chk(req, "rsp_paddr", 32'(rsp_paddr), eh ? 32'({ep, off}) : 32'd0);
  endtask

  task automatic fill(input bit ins, input logic [13:0] vpn, input logic [7:0] ppn);
    @(negedge clk);
    fill_valid = 1'b1; fill_is_instr = ins; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic chk_counters(input string req);
    chk(req, "icnt_access", 32'(icnt_access), 32'(m_iacc));
    chk(req, "icnt_hit", 32'(icnt_hit), 32'(m_ihit));
    chk(req, "dcnt_access", 32'(dcnt_access), 32'(m_dacc));
    chk(req, "dcnt_hit", 32'(dcnt_hit), 32'(m_dhit));
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk_counters("R1");
    lookup(1'b1, 1'b0, 14'h0003, 12'h010, 1'b0, 8'h00, "R1");
    lookup(1'b0, 1'b0, 14'h0003, 12'h010, 1'b0, 8'h00, "R1");
  endtask

  task automatic t_basic();
    fill(1'b1, 14'h0123, 8'h5A);
    lookup(1'b1, 1'b1, 14'h0123, 12'hABC, 1'b1, 8'h5A, "R2");
    chk("R2", "rsp_is_write", 32'(rsp_is_write), 32'd1);
    chk("R2", "rsp_is_instr", 32'(rsp_is_instr), 32'd1);
    chk("R2", "rsp_vpn", 32'(rsp_vpn), 32'h0123);
    chk_counters("R8");
    lookup(1'b1, 1'b0, 14'h0127, 12'h001, 1'b0, 8'h00, "R3");
    lookup(1'b0, 1'b0, 14'h0123, 12'h002, 1'b0, 8'h00, "R4");
    chk("R2", "rsp_is_instr data", 32'(rsp_is_instr), 32'd0);
    fill(1'b0, 14'h0123, 8'h33);
    lookup(1'b0, 1'b1, 14'h0123, 12'h0FF, 1'b1, 8'h33, "R4");
    lookup(1'b1, 1'b0, 14'h0123, 12'h0FF, 1'b1, 8'h5A, "R4");
    chk_counters("R8");
  endtask

  task automatic t_capacity();
    do_flush();
    for (int k = 0; k < 16; k++) fill(1'b1, 14'(14'h0200 + k), 8'(8'h80 + k));
    for (int k = 0; k < 32; k++) fill(1'b0, 14'(14'h0300 + k), 8'(8'h40 + k));
    for (int k = 0; k < 16; k++) lookup(1'b1, 1'b0, 14'(14'h0200 + k), 12'h123, 1'b1, 8'(8'h80 + k), "R3");
    for (int k = 0; k < 32; k++) lookup(1'b0, 1'b0, 14'(14'h0300 + k), 12'h456, 1'b1, 8'(8'h40 + k), "R3");
  endtask

  task automatic t_refill_lru();
    do_flush();
    fill(1'b1, 14'h0040, 8'h01);
    fill(1'b1, 14'h0044, 8'h02);
    fill(1'b1, 14'h0048, 8'h03);
    fill(1'b1, 14'h0044, 8'h09);
    fill(1'b1, 14'h004C, 8'h04);
    lookup(1'b1, 1'b0, 14'h0040, 12'h000, 1'b1, 8'h01, "R5");
    lookup(1'b1, 1'b0, 14'h0044, 12'h000, 1'b1, 8'h09, "R5");
    lookup(1'b1, 1'b0, 14'h0048, 12'h000, 1'b1, 8'h03, "R5");
    lookup(1'b1, 1'b0, 14'h004C, 12'h000, 1'b1, 8'h04, "R5");
    lookup(1'b1, 1'b0, 14'h0040, 12'h000, 1'b1, 8'h01, "R6");
    fill(1'b1, 14'h0050, 8'h05);
    lookup(1'b1, 1'b0, 14'h0044, 12'h000, 1'b0, 8'h00, "R6");
    lookup(1'b1, 1'b0, 14'h0040, 12'h000, 1'b1, 8'h01, "R6");
    lookup(1'b1, 1'b0, 14'h0048, 12'h000, 1'b1, 8'h03, "R6");
    lookup(1'b1, 1'b0, 14'h004C, 12'h000, 1'b1, 8'h04, "R6");
    lookup(1'b1, 1'b0, 14'h0050, 12'h000, 1'b1, 8'h05, "R6");
    fill(1'b1, 14'h0054, 8'h06);
    lookup(1'b1, 1'b0, 14'h0040, 12'h000, 1'b0, 8'h00, "R6");
    lookup(1'b1, 1'b0, 14'h0054, 12'h000, 1'b1, 8'h06, "R6");
  endtask

  task automatic t_random();
    logic [13:0] held [4];
    logic [1:0] v;
    do_flush();
    for (int k = 0; k < 4; k++) begin
      held[k] = 14'(14'h0400 + 8 * k);
      fill(1'b0, held[k], held[k][7:0]);
    end
    for (int n = 0; n < 5; n++) begin
      logic [13:0] nv;
      nv = 14'(14'h0420 + 8 * n);
      v = m_lfsr[1:0];
      m_lfsr = lfsr_next(m_lfsr);
      held[v] = nv;
      fill(1'b0, nv, nv[7:0]);
      for (int p = 0; p < 9; p++) begin
        logic [13:0] pv;
        bit present;
        pv = (p < 4) ? 14'(14'h0400 + 8 * p) : 14'(14'h0420 + 8 * (p - 4));
        present = 1'b0;
        for (int q = 0; q < 4; q++) if (held[q] == pv) present = 1'b1;
        if (p - 4 <= n) lookup(1'b0, 1'b0, pv, 12'h777, present, pv[7:0], "R7");
      end
    end
  endtask

  task automatic t_priority();
    do_flush();
    @(negedge clk);
    lk_valid = 1'b1; lk_is_instr = 1'b1; lk_is_write = 1'b0; lk_vaddr = {14'h0070, 12'h000};
    fill_valid = 1'b1; fill_is_instr = 1'b1; fill_vpn = 14'h0070; fill_ppn = 8'h77;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    model_count(1'b1, 1'b0);
    chk("R11", "same-cycle fill leaves lookup a miss", 32'(rsp_hit), 32'd0);
    lookup(1'b1, 1'b0, 14'h0070, 12'h010, 1'b1, 8'h77, "R11");
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_is_instr = 1'b1; fill_vpn = 14'h0071; fill_ppn = 8'h71;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup(1'b1, 1'b0, 14'h0071, 12'h000, 1'b0, 8'h00, "R11");
    lookup(1'b1, 1'b0, 14'h0070, 12'h000, 1'b0, 8'h00, "R10");
    chk_counters("R10");
  endtask

  task automatic t_saturate();
    fill(1'b0, 14'h0005, 8'h55);
    for (int k = 0; k < CMAX + 3; k++) lookup(1'b0, 1'b0, 14'h0005, 12'h000, 1'b1, 8'h55, "R9");
    chk("R9", "dcnt_access saturated", 32'(dcnt_access), 32'(CMAX));
    chk("R9", "dcnt_hit saturated", 32'(dcnt_hit), 32'(CMAX));
    chk_counters("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_capacity();
    t_refill_lru();
    t_random();
    t_priority();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule